// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

A synchronous single-port memory of 36-bit words split into four 9-bit byte lanes. Every command input (chip select, write enable, the four lane write enables and the address) is captured on the rising clock edge. Reads are pipelined: the word appears on the output one cycle after its address was captured. Writes are late: the data for a write is captured on the edge after the one that took its address.

Written data does not go to the storage array at once. It waits in a one-entry pending buffer, together with its address and lane enables, until the data of the next write arrives. A read that hits the pending address is served from the buffer, merged lane by lane over the array word, so that every read sees the newest data.

The shared data bus is modelled as an input word, an output word and an output-drive flag. An asynchronous output enable and a sleep input can both force the bus to float. The nominal organisation is 1M words; the address width is a parameter, and the default is kept small.

Top module: `lw_sram_core`

## Requirements
- R1: A read (cs_n low, we_n high, sleep low) captured at edge k puts the addressed word on dout after edge k+1, and dout_oe is high in that cycle while oe_n and sleep are low.
- R2: A write (cs_n low, we_n low, sleep low) captured at edge k takes din at edge k+1. bw_n[i] low writes bits 9i+8..9i: bit 0 is bits 8:0 and bit 3 is bits 35:27. Lanes with bw_n[i] high keep their old contents.
- R3: A read whose address matches the pending write returns that write's enabled lanes over the stored word. This also holds for a read whose address is captured on the same edge as the write's data.
- R4: The pending write moves into the array when the data of the following write is captured. After that, its value is still returned for its address.
- R5: A cycle captured with cs_n high performs no operation, and dout_oe is low in the cycle that follows it.
- R6: oe_n high drives dout_oe low at once, with no clock edge needed. A read issued while the bus is held off still runs as a dummy read and does not delay the reads that follow it.
- R7: sleep high holds dout_oe low. A cycle captured with sleep high performs neither a read nor a write.
- R8: A read captured directly after a deselect cycle gives valid output in the next cycle, with no added latency.
- R9: Synchronous reset drops the pending write, so its data is lost, and clears the output-drive pipeline, so dout_oe is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all captures on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low; high means read |
| bw_n | input | 4 | Lane write enables, active low, bit i covers bits 9i+8..9i |
| addr | input | AW | Word address |
| din | input | 36 | Write data, captured one edge after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dout | output | 36 | Read data register |
| dout_oe | output | 1 | High when the data bus is driven |

## Verification
The assertions take it that all control inputs are known at each rising edge. They also take it that cs_n is high while reset is held, so that no operation is captured around reset, and their antecedents skip any cycle whose history reaches back into reset. The stimulus changes inputs only on the falling edge, keeps chip select off during reset, and drains any write still waiting for its data before it asserts reset. All addresses are written once before the first read, so no read returns an uninitialised word.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Overlay the selected lanes of upd onto base.
    function automatic word_t lane_merge(input word_t base, input word_t upd, input lane_t sel);
        word_t r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (sel[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/lw_sram_issue.sv
module lw_sram_issue
    import lw_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          sleep,
    input  logic [3:0]    bw_n,
    input  logic [AW-1:0] addr,
    output op_e           op_q,
    output logic [AW-1:0] addr_q,
    output lane_t         lane_q
);

    op_e op_d;

    always_comb begin
        if (cs_n || sleep) op_d = OP_IDLE;
        else if (we_n)     op_d = OP_READ;
        else               op_d = OP_WRITE;
    end

    always_ff @(posedge clk) begin
        if (rst) op_q <= OP_IDLE;
        else     op_q <= op_d;
    end

    always_ff @(posedge clk) begin
        addr_q <= addr;
        lane_q <= ~bw_n;
    end

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
    import lw_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [AW-1:0] op_addr,
    input  lane_t         op_lane,
    input  word_t         din,
    input  word_t         arr_word,
    output logic          cm_we,
    output logic [AW-1:0] cm_addr,
    output lane_t         cm_lane,
    output word_t         cm_data,
    output word_t         rd_word,
    output logic          pend_v
);

    logic [AW-1:0] pend_a;
    lane_t         pend_l;
    word_t         pend_d;
    logic          hit;

    always_ff @(posedge clk) begin
        if (rst)                 pend_v <= 1'b0;
        else if (op == OP_WRITE) pend_v <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (op == OP_WRITE) begin
            pend_a <= op_addr;
            pend_l <= op_lane;
            pend_d <= din;
        end
    end

    // The older entry drains as the next write's data lands.
    assign cm_we   = (op == OP_WRITE) && pend_v && !rst;
    assign cm_addr = pend_a;
    assign cm_lane = pend_l;
    assign cm_data = pend_d;

    assign hit     = pend_v && (pend_a == op_addr);
    assign rd_word = hit ? lane_merge(arr_word, pend_d, pend_l) : arr_word;

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  lane_t         wlane,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wlane[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
    import lw_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic [3:0]    bw_n,
    input  logic [AW-1:0] addr,
    input  logic [35:0]   din,
    input  logic          oe_n,
    input  logic          sleep,
    output logic [35:0]   dout,
    output logic          dout_oe
);

    op_e           op_q;
    logic [AW-1:0] addr_q;
    lane_t         lane_q;
    logic          cm_we;
    logic [AW-1:0] cm_addr;
    lane_t         cm_lane;
    word_t         cm_data;
    word_t         arr_word;
    word_t         rd_word;
    logic          pend_v;
    logic          drive_q;
    word_t         dout_q;

    lw_sram_issue #(.AW(AW)) u_issue (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .we_n   (we_n),
        .sleep  (sleep),
        .bw_n   (bw_n),
        .addr   (addr),
        .op_q   (op_q),
        .addr_q (addr_q),
        .lane_q (lane_q)
    );

    lw_sram_wbuf #(.AW(AW)) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .op       (op_q),
        .op_addr  (addr_q),
        .op_lane  (lane_q),
        .din      (din),
        .arr_word (arr_word),
        .cm_we    (cm_we),
        .cm_addr  (cm_addr),
        .cm_lane  (cm_lane),
        .cm_data  (cm_data),
        .rd_word  (rd_word),
        .pend_v   (pend_v)
    );

    lw_sram_array #(.AW(AW)) u_array (
        .clk   (clk),
        .we    (cm_we),
        .waddr (cm_addr),
        .wlane (cm_lane),
        .wdata (cm_data),
        .raddr (addr_q),
        .rdata (arr_word)
    );

    always_ff @(posedge clk) begin
        if (rst) drive_q <= 1'b0;
        else     drive_q <= (op_q == OP_READ);
    end

    always_ff @(posedge clk) begin
        if (op_q == OP_READ) dout_q <= rd_word;
    end

    assign dout    = dout_q;
    assign dout_oe = drive_q && !oe_n && !sleep;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic we_n,
    input logic sleep,
    input logic oe_n,
    input logic dout_oe,
    input logic pend_v
);

    assert_read_drives_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2) && $past(!cs_n && we_n && !sleep, 2) && !oe_n && !sleep)
        |-> dout_oe);

    assert_write_buffers_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2) && $past(!cs_n && !we_n && !sleep, 2))
        |-> pend_v);

    assert_deselect_floats_R5: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n, 2) |-> !dout_oe);

    assert_sleep_no_read_R7: assert property (@(posedge clk) disable iff (rst)
        $past(sleep, 2) |-> !dout_oe);

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!pend_v && !dout_oe));

endmodule

bind lw_sram_core lw_sram_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .sleep   (sleep),
    .oe_n    (oe_n),
    .dout_oe (dout_oe),
    .pend_v  (pend_v)
);

// File: tb/lw_sram_core_test.sv
`timescale 1ns/1ps
module lw_sram_core_test;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [35:0]   din = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [35:0]   dout;
    logic          dout_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Model state: committed words plus the one waiting write.
    logic [35:0]   m_arr [DEPTH];
    logic          p_v = 1'b0;
    logic [AW-1:0] p_a;
    logic [3:0]    p_l;
    logic [35:0]   p_d;
    logic          prev_wr = 1'b0;
    logic [AW-1:0] prev_a;
    logic [3:0]    prev_l;
    logic          s1_rd = 1'b0, s2_rd = 1'b0;
    logic [35:0]   s1_d, s2_d;
    string         s1_t = "R5", s2_t = "R5";

    lw_sram_core #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
        .din(din), .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_oe(dout_oe)
    );

    always #4 clk = ~clk;

    function automatic logic [35:0] mix(input logic [35:0] base, input logic [35:0] upd,
                                        input logic [3:0] en);
        logic [35:0] r;
        r = base;
        for (int i = 0; i < 4; i++) if (en[i]) r[i*9 +: 9] = upd[i*9 +: 9];
        return r;
    endfunction

    task automatic step(input logic c_n, input logic w_n, input logic [3:0] bwn,
                        input logic [AW-1:0] a, input logic oen, input logic slp,
                        input string tag);
        logic        exp_oe;
        logic [63:0] r;
        @(negedge clk);
        exp_oe = s2_rd && !oe_n && !sleep;
        n_chk++;
        if (dout_oe !== exp_oe || (exp_oe && dout !== s2_d)) begin
            n_fail++;
            $display("FAIL %s: dout_oe=%b dout=%h expected dout_oe=%b dout=%h",
                     s2_t, dout_oe, dout, exp_oe, s2_d);
        end
        if (exp_oe && s2_t == "R6") begin
            oe_n = 1'b1; #1;
            n_chk++;
            if (dout_oe !== 1'b0) begin
                n_fail++; $display("FAIL R6: async dout_oe=%b expected 0", dout_oe);
            end
            oe_n = 1'b0; #1;
            n_chk++;
            if (dout_oe !== 1'b1) begin
                n_fail++; $display("FAIL R6: async dout_oe=%b expected 1", dout_oe);
            end
        end
        s2_rd = s1_rd; s2_d = s1_d; s2_t = s1_t;
        r = {$urandom(), $urandom()};
        din = r[35:0];
        if (prev_wr) begin
            if (p_v) m_arr[p_a] = mix(m_arr[p_a], p_d, p_l);
            p_v = 1'b1; p_a = prev_a; p_l = prev_l; p_d = r[35:0];
        end
        cs_n = c_n; we_n = w_n; bw_n = bwn; addr = a; oe_n = oen; sleep = slp;
        s1_rd = !c_n && w_n && !slp;
        s1_t  = tag;
        s1_d  = (p_v && p_a == a) ? mix(m_arr[a], p_d, p_l) : m_arr[a];
        prev_wr = !c_n && !w_n && !slp;
        prev_a  = a;
        prev_l  = ~bwn;
    endtask

    task automatic do_reset();
        step(1'b1, 1'b1, 4'hF, '0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b1, 4'hF, '0, 1'b0, 1'b0, "R5");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        p_v = 1'b0; prev_wr = 1'b0; s1_rd = 1'b0; s2_rd = 1'b0;
        n_chk++;
        if (dout_oe !== 1'b0) begin
            n_fail++; $display("FAIL R9: dout_oe=%b expected 0 after reset", dout_oe);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_chk++;
        if (dout_oe !== 1'b0) begin
            n_fail++; $display("FAIL R9: dout_oe=%b expected 0 at start", dout_oe);
        end

        // R2: fill every word with full-width writes
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, 4'h0, AW'(i), 1'b0, 1'b0, "R2");

        // R3: read straight after a write, then a lane-b update merged over it
        step(1'b0, 1'b0, 4'h0, 6'd5, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b1, 4'hF, 6'd5, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, 4'b1101, 6'd5, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b1, 4'hF, 6'd5, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, 4'b0110, 6'd5, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b1, 4'hF, 6'd5, 1'b0, 1'b0, "R3");

        // R4: a committed write is still visible once another write replaces it
        step(1'b0, 1'b0, 4'h0, 6'd7, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 4'b1110, 6'd9, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b1, 4'hF, 6'd0, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, 4'hF, 6'd7, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 4'hF, 6'd9, 1'b0, 1'b0, "R3");

        // R5 and R8: deselect cycles, then a read right after one
        step(1'b1, 1'b0, 4'h0, 6'd9, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, 4'hF, 6'd9, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b1, 4'hF, 6'd1, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, 4'hF, 6'd1, 1'b0, 1'b0, "R8");

        // R6: dummy read under oe_n, then an undelayed read with async probes
        step(1'b0, 1'b1, 4'hF, 6'd2, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 4'hF, 6'd3, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 4'hF, 6'd4, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 4'hF, 6'd0, 1'b0, 1'b0, "R5");

        // R7: sleep hides output and blocks a read and a write
        step(1'b0, 1'b1, 4'hF, 6'd2, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 4'hF, 6'd3, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, 4'h0, 6'd3, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b1, 4'hF, 6'd0, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 4'hF, 6'd3, 1'b0, 1'b0, "R7");
        step(1'b1, 1'b1, 4'hF, 6'd0, 1'b0, 1'b0, "R5");

        // R9: reset drops a pending write
        step(1'b0, 1'b0, 4'h0, 6'd11, 1'b0, 1'b0, "R2");
        do_reset();
        step(1'b0, 1'b1, 4'hF, 6'd11, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b1, 4'hF, 6'd0, 1'b0, 1'b0, "R5");

        // Random mix on a narrow address window for frequent buffer hits
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [AW-1:0] a;
            logic oen, slp;
            k   = int'($urandom_range(0, 9));
            a   = AW'($urandom_range(0, 7));
            oen = ($urandom_range(0, 9) == 0);
            slp = ($urandom_range(0, 19) == 0);
            if (k < 4)       step(1'b0, 1'b1, 4'hF, a, oen, slp, "R1");
            else if (k < 8)  step(1'b0, 1'b0, 4'($urandom_range(0, 15)), a, oen, slp, "R2");
            else             step(1'b1, 1'($urandom_range(0, 1)), 4'hF, a, oen, slp, "R5");
        end
        step(1'b1, 1'b1, 4'hF, '0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b1, 4'hF, '0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b1, 4'hF, '0, 1'b0, 1'b0, "R5");

        done = 1;
        summary();
        $finish;
    end

endmodule